// File: doc/BRIEF.md
# Address Table Command Engine

This block keeps a small forwarding table of MAC addresses and runs host commands against it. Each slot holds a 48-bit MAC, a 6-bit database number, a 4-bit entry state, a trunk flag and a port vector. A host talks to it through five 16-bit registers: a command register with a busy bit, an entry-data register and three MAC registers. The host writes the operands, starts a command by writing the command register with the busy bit set, and then polls until busy reads zero.

Every command walks the table one slot per clock, so a command takes the same number of cycles whatever it does. Load inserts, overwrites or purges one entry. Get-next returns the next entry of one database in ascending MAC order. A single flush-or-move command, steered by the entry state in the data register, either drops entries or moves a port in their port vectors. It can cover all entries or only non-static ones, in one database or in all of them.

Top module: `addr_table_engine`

Register addresses (`regAddr`): 0 command, 1 entry data, 2 MAC bytes 0-1, 3 MAC bytes 2-3, 4 MAC bytes 4-5. Command codes (command bits 14:12): 0 no-op, 1 flush/move everything, 2 flush/move non-static in all databases, 3 load/purge, 4 get-next, 5 flush/move everything in one database, 6 flush/move non-static in one database.

## Requirements
- R1: Writing the command register with bit 15 set while idle starts the command. Bit 15 then reads 1 until the command ends and reads 0 after that. After reset every register reads 0.
- R2: While a command runs, host writes to any register are ignored. The registers read back their earlier values afterwards.
- R3: The entry-data register holds the state in bits 3:0, the port vector in bits 11:4 and the trunk flag in bit 15. Bits 14:12 read 0.
- R4: Each MAC register holds two bytes, with the lower-numbered byte in bits 15:8. MAC byte 0 is the most significant byte of the address.
- R5: A load (code 3) with a nonzero state writes the MAC, the database and the data fields. If an entry with the same MAC and database exists, the load overwrites it.
- R6: A load with state 0 removes the entry that matches both MAC and database. Other entries are kept.
- R7: A load of a new entry into a full table sets command bit 4 and leaves the table unchanged. The next command start clears that bit. A load that overwrites an existing entry succeeds even when the table is full.
- R8: Get-next (code 4) returns the valid entry of the selected database with the smallest MAC strictly above the MAC registers. It writes that entry into the data and MAC registers, so repeated calls walk the database in ascending order. Entries of other databases are skipped.
- R9: When get-next finds no such entry, it returns state 0 and sets the MAC registers to all ones.
- R10: The database number is taken from command bits 3:0 (low part) and bits 9:8 (high part). Both parts read back.
- R11: With data state 0, codes 1, 2, 5 and 6 remove the entries in scope. Codes 2 and 6 spare static entries (state 0xF). Codes 5 and 6 touch only the selected database.
- R12: With data state 0xF, the same codes act as a move. Port-vector bits 3:0 give the source port and bits 7:4 the destination port. In each in-scope entry that holds the source port, that bit is cleared and the destination bit is set. A destination of 0xF only clears the source bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for reads and writes |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data of the addressed register (combinational) |

## Verification
The assertions check on every cycle how the busy bit relates to the control sequencer. Busy must follow a valid start and must match the sequencer's non-idle state. A command must hold busy for at least two cycles. The full-table flag may only rise as a command completes and must clear when a command starts. Only the bench scenarios can show the table contents: ascending get-next order, the end-of-walk marker, purge and overwrite, the four flush scopes, port moves and removals, and writes ignored while busy. These are all seen through get-next walks and register reads.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int DB_W = 6;
  localparam int MAC_W = 48;

  localparam logic [2:0] ADDR_OP   = 3'd0;
  localparam logic [2:0] ADDR_DATA = 3'd1;
  localparam logic [2:0] ADDR_MAC0 = 3'd2;
  localparam logic [2:0] ADDR_MAC1 = 3'd3;
  localparam logic [2:0] ADDR_MAC2 = 3'd4;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_FM_ALL   = 3'd1,
    CMD_FM_NS    = 3'd2,
    CMD_LOAD     = 3'd3,
    CMD_NEXT     = 3'd4,
    CMD_FM_DB    = 3'd5,
    CMD_FM_DB_NS = 3'd6,
    CMD_RSVD     = 3'd7
  } cmd_t;

  typedef struct packed {
    logic clear;
    logic scan;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/atu_control.sv
module atu_control
  import atu_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDXW = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  output strobe_t         stb,
  output logic [IDXW-1:0] idx,
  output logic            idle
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_COMMIT} seq_t;
  seq_t seqState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqState <= S_IDLE;
      idx      <= '0;
    end else begin
      unique case (seqState)
        S_IDLE: if (start) begin
          seqState <= S_SCAN;
          idx      <= '0;
        end
        S_SCAN: begin
          if (idx == IDXW'(ENTRIES - 1)) seqState <= S_COMMIT;
          else idx <= idx + 1'b1;
        end
        S_COMMIT: seqState <= S_IDLE;
        default:  seqState <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.clear  = start && (seqState == S_IDLE);
    stb.scan   = (seqState == S_SCAN);
    stb.commit = (seqState == S_COMMIT);
  end
  assign idle = (seqState == S_IDLE);
endmodule

// File: rtl/atu_datapath.sv
module atu_datapath
  import atu_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PORTS = 8,
  localparam int IDXW = $clog2(ENTRIES),
  localparam int HALF = PORTS / 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [2:0]      addr,
  input  logic [15:0]     wrData,
  input  strobe_t         stb,
  input  logic [IDXW-1:0] idx,
  output logic            start,
  output logic            opBusy,
  output logic            fullViol,
  output logic [15:0]     rdData
);
  // table storage
  logic [ENTRIES-1:0] tValid;
  logic [MAC_W-1:0]   tMac   [ENTRIES];
  logic [DB_W-1:0]    tDb    [ENTRIES];
  logic [3:0]         tState [ENTRIES];
  logic [PORTS-1:0]   tPv    [ENTRIES];
  logic               tTrunk [ENTRIES];

  // host registers
  cmd_t             opCode;
  logic [DB_W-1:0]  opDb;
  logic [3:0]       dState;
  logic [PORTS-1:0] dPv;
  logic             dTrunk;
  logic [MAC_W-1:0] macReg;

  // scan trackers
  logic             matchHit, freeHit, bestHit;
  logic [IDXW-1:0]  matchIdx, freeIdx, bestIdx;
  logic [MAC_W-1:0] bestMac;

  assign start = wrEn && (addr == ADDR_OP) && wrData[15] && !opBusy;

  // scope decode for the flush/move family
  logic isFm, dbAll, classAll, inScope, curMatch, curBetter;
  logic flushHit, moveHit;
  logic [PORTS-1:0] srcMask, dstMask, movedPv;
  logic [HALF-1:0]  srcPort, dstPort;

  always_comb begin
    isFm     = opCode inside {CMD_FM_ALL, CMD_FM_NS, CMD_FM_DB, CMD_FM_DB_NS};
    dbAll    = opCode inside {CMD_FM_ALL, CMD_FM_NS};
    classAll = opCode inside {CMD_FM_ALL, CMD_FM_DB};
    inScope  = tValid[idx] && (dbAll || tDb[idx] == opDb) &&
               (classAll || tState[idx] != 4'hF);
    srcPort  = dPv[HALF-1:0];
    dstPort  = dPv[PORTS-1:HALF];
    srcMask  = PORTS'(1) << srcPort;
    dstMask  = (&dstPort) ? '0 : (PORTS'(1) << dstPort);
    movedPv  = (tPv[idx] & ~srcMask) | dstMask;
    flushHit = stb.scan && isFm && inScope && (dState == 4'h0);
    moveHit  = stb.scan && isFm && inScope && (dState == 4'hF) &&
               |(tPv[idx] & srcMask);
    curMatch = tValid[idx] && (tMac[idx] == macReg) && (tDb[idx] == opDb);
    curBetter = tValid[idx] && (tDb[idx] == opDb) && (tMac[idx] > macReg) &&
                (!bestHit || tMac[idx] < bestMac);
  end

  // trackers
  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      matchHit <= 1'b0; freeHit <= 1'b0; bestHit <= 1'b0;
      matchIdx <= '0;   freeIdx <= '0;   bestIdx <= '0;
      bestMac  <= '0;
    end else if (stb.scan) begin
      if (curMatch) begin
        matchHit <= 1'b1;
        matchIdx <= idx;
      end
      if (!tValid[idx] && !freeHit) begin
        freeHit <= 1'b1;
        freeIdx <= idx;
      end
      if (curBetter) begin
        bestHit <= 1'b1;
        bestIdx <= idx;
        bestMac <= tMac[idx];
      end
    end
  end

  logic loadCommit, loadWrite;
  logic [IDXW-1:0] loadIdx;
  always_comb begin
    loadCommit = stb.commit && (opCode == CMD_LOAD);
    loadWrite  = loadCommit && (dState != 4'h0) && (matchHit || freeHit);
    loadIdx    = matchHit ? matchIdx : freeIdx;
  end

  // valid bits
  always_ff @(posedge clk) begin
    if (!rstN) tValid <= '0;
    else if (flushHit) tValid[idx] <= 1'b0;
    else if (loadCommit && dState == 4'h0 && matchHit) tValid[matchIdx] <= 1'b0;
    else if (loadWrite) tValid[loadIdx] <= 1'b1;
  end

  // entry payload
  always_ff @(posedge clk) begin
    if (moveHit) tPv[idx] <= movedPv;
    else if (loadWrite) begin
      tMac[loadIdx]   <= macReg;
      tDb[loadIdx]    <= opDb;
      tState[loadIdx] <= dState;
      tPv[loadIdx]    <= dPv;
      tTrunk[loadIdx] <= dTrunk;
    end
  end

  // host registers and command completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opBusy <= 1'b0; fullViol <= 1'b0; opCode <= CMD_NOP; opDb <= '0;
      dState <= '0;   dPv <= '0;        dTrunk <= 1'b0;    macReg <= '0;
    end else if (!opBusy) begin
      if (wrEn) begin
        unique case (addr)
          ADDR_OP: begin
            opCode <= cmd_t'(wrData[14:12]);
            opDb   <= {wrData[9:8], wrData[3:0]};
            if (wrData[15]) begin
              opBusy   <= 1'b1;
              fullViol <= 1'b0;
            end
          end
          ADDR_DATA: begin
            dState <= wrData[3:0];
            dPv    <= wrData[4 +: PORTS];
            dTrunk <= wrData[15];
          end
          ADDR_MAC0: macReg[47:32] <= wrData;
          ADDR_MAC1: macReg[31:16] <= wrData;
          ADDR_MAC2: macReg[15:0]  <= wrData;
          default: ;
        endcase
      end
    end else if (stb.commit) begin
      opBusy <= 1'b0;
      if (loadCommit && dState != 4'h0 && !matchHit && !freeHit) fullViol <= 1'b1;
      if (opCode == CMD_NEXT) begin
        if (bestHit) begin
          dState <= tState[bestIdx];
          dPv    <= tPv[bestIdx];
          dTrunk <= tTrunk[bestIdx];
          macReg <= bestMac;
        end else begin
          dState <= '0;
          dPv    <= '0;
          dTrunk <= 1'b0;
          macReg <= '1;
        end
      end
    end
  end

  // read mux
  logic [15:0] dataWord;
  always_comb begin
    dataWord = '0;
    dataWord[3:0] = dState;
    dataWord[4 +: PORTS] = dPv;
    dataWord[15] = dTrunk;
    unique case (addr)
      ADDR_OP:   rdData = {opBusy, opCode, 2'b00, opDb[5:4], 3'b000, fullViol, opDb[3:0]};
      ADDR_DATA: rdData = dataWord;
      ADDR_MAC0: rdData = macReg[47:32];
      ADDR_MAC1: rdData = macReg[31:16];
      ADDR_MAC2: rdData = macReg[15:0];
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/addr_table_engine.sv
module addr_table_engine
  import atu_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PORTS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData
);
  localparam int IDXW = $clog2(ENTRIES);

  strobe_t         stb;
  logic [IDXW-1:0] scanIdx;
  logic            start, opBusy, fullViol, ctrlIdle;

  atu_control #(.ENTRIES(ENTRIES)) ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .stb(stb), .idx(scanIdx), .idle(ctrlIdle)
  );

  atu_datapath #(.ENTRIES(ENTRIES), .PORTS(PORTS)) dp (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .stb(stb), .idx(scanIdx), .start(start), .opBusy(opBusy),
    .fullViol(fullViol), .rdData(regRdData)
  );
endmodule

// File: rtl/atu_engine_checker.sv
module atu_engine_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [2:0]  regAddr,
  input logic [15:0] regWrData,
  input logic        opBusy,
  input logic        fullViol,
  input logic        ctrlIdle
);
  logic hostStart;
  assign hostStart = regWrEn && (regAddr == 3'd0) && regWrData[15] && !opBusy;

  p_start_sets_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    hostStart |=> opBusy);

  p_busy_follows_seq_r1: assert property (@(posedge clk) disable iff (!rstN)
    opBusy != ctrlIdle);

  p_busy_min_span_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(opBusy) |-> $past(opBusy, 2));

  p_full_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullViol) |-> $fell(opBusy));

  p_full_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    hostStart |=> !fullViol);
endmodule

bind addr_table_engine atu_engine_checker chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .opBusy(opBusy), .fullViol(fullViol), .ctrlIdle(ctrlIdle)
);

// File: tb/addr_table_engine_test.sv
`timescale 1ns/1ps
module addr_table_engine_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  int compared = 0;
  int mismatched = 0;
  localparam logic [47:0] ALL1 = 48'hFFFF_FFFF_FFFF;

  always #2 clk = ~clk;

  addr_table_engine uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [15:0] opWord(input logic go, input logic [2:0] code,
                                         input logic [5:0] db);
    return {go, code, 2'b00, db[5:4], 4'b0000, db[3:0]};
  endfunction

  function automatic logic [15:0] dataWord(input logic trunk, input logic [7:0] pv,
                                           input logic [3:0] st);
    return {trunk, 3'b000, pv, st};
  endfunction

  task automatic runOp(input logic [2:0] code, input logic [5:0] db);
    logic [15:0] v;
    wr(3'd0, opWord(1'b1, code, db));
    for (int i = 0; i < 100; i++) begin
      rd(3'd0, v);
      if (!v[15]) break;
    end
    if (v[15]) chk("R1 busy never cleared", {47'd0, v[15]}, 48'd0);
  endtask

  task automatic setMac(input logic [47:0] m);
    wr(3'd2, m[47:32]); wr(3'd3, m[31:16]); wr(3'd4, m[15:0]);
  endtask

  task automatic getMac(output logic [47:0] m);
    logic [15:0] a, b, c;
    rd(3'd2, a); rd(3'd3, b); rd(3'd4, c);
    m = {a, b, c};
  endtask

  task automatic loadEntry(input logic [5:0] db, input logic [47:0] m,
                           input logic [3:0] st, input logic [7:0] pv, input logic tr);
    setMac(m);
    wr(3'd1, dataWord(tr, pv, st));
    runOp(3'd3, db);
  endtask

  task automatic nextEntry(input logic [5:0] db, output logic [15:0] d, output logic [47:0] m);
    runOp(3'd4, db);
    rd(3'd1, d);
    getMac(m);
  endtask

  task automatic expectNext(input string tag, input logic [5:0] db,
                            input logic [47:0] expMac, input logic [15:0] expData);
    logic [15:0] d; logic [47:0] m;
    nextEntry(db, d, m);
    chk({tag, " mac"}, m, expMac);
    chk({tag, " data"}, {32'd0, d}, {32'd0, expData});
  endtask

  task automatic flushAll();
    wr(3'd1, 16'h0000);
    runOp(3'd1, 6'd0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset register value", {32'd0, v}, 48'd0);
    end
  endtask

  task automatic t_layout();
    logic [15:0] v; logic [47:0] m;
    wr(3'd1, 16'hFFFF); rd(3'd1, v);
    chk("R3 data unused bits read zero", {32'd0, v}, {32'd0, 16'h8FFF});
    wr(3'd1, 16'h0A5C); rd(3'd1, v);
    chk("R3 data fields readback", {32'd0, v}, {32'd0, 16'h0A5C});
    setMac(48'h0102_0304_0506); getMac(m);
    chk("R4 mac register readback", m, 48'h0102_0304_0506);
    wr(3'd0, 16'h0302); rd(3'd0, v);
    chk("R10 db field readback", {32'd0, v}, {32'd0, 16'h0302});
  endtask

  task automatic t_walk();
    logic [15:0] v;
    flushAll();
    loadEntry(6'd2, 48'h0011_2233_4455, 4'h7, 8'h03, 1'b0);
    loadEntry(6'd2, 48'h0011_2233_44AA, 4'h7, 8'h81, 1'b1);
    loadEntry(6'd2, 48'h0000_0000_0010, 4'h5, 8'h02, 1'b0);
    loadEntry(6'd3, 48'h0000_0000_0020, 4'h7, 8'h04, 1'b0);
    loadEntry(6'h22, 48'h0000_0000_0030, 4'h7, 8'h08, 1'b0);
    setMac(48'd0);
    expectNext("R8 first in ascending order", 6'd2, 48'h0000_0000_0010, dataWord(1'b0, 8'h02, 4'h5));
    expectNext("R8 second in ascending order", 6'd2, 48'h0011_2233_4455, dataWord(1'b0, 8'h03, 4'h7));
    expectNext("R4 R8 third with byte order", 6'd2, 48'h0011_2233_44AA, dataWord(1'b1, 8'h81, 4'h7));
    expectNext("R9 end of walk", 6'd2, ALL1, 16'h0000);
    setMac(48'd0);
    expectNext("R10 high db bits select database", 6'h22, 48'h0000_0000_0030, dataWord(1'b0, 8'h08, 4'h7));
    rd(3'd0, v);
    chk("R10 high db bits read back", {32'd0, v}, {32'd0, opWord(1'b0, 3'd4, 6'h22)});
  endtask

  task automatic t_loadPurge();
    loadEntry(6'd2, 48'h0011_2233_4455, 4'hE, 8'h10, 1'b0);
    setMac(48'h0011_2233_4454);
    expectNext("R5 overwrite in place", 6'd2, 48'h0011_2233_4455, dataWord(1'b0, 8'h10, 4'hE));
    loadEntry(6'd2, 48'h0011_2233_4455, 4'h0, 8'h00, 1'b0);
    setMac(48'h0000_0000_0010);
    expectNext("R6 purged entry skipped", 6'd2, 48'h0011_2233_44AA, dataWord(1'b1, 8'h81, 4'h7));
    setMac(48'd0);
    expectNext("R6 other entry kept", 6'd2, 48'h0000_0000_0010, dataWord(1'b0, 8'h02, 4'h5));
  endtask

  task automatic t_busyIgnore();
    logic [15:0] v; logic [47:0] m;
    setMac(48'hAAAA_BBBB_CCCC);
    wr(3'd1, 16'h0123);
    wr(3'd0, opWord(1'b1, 3'd0, 6'd1));
    rd(3'd0, v);
    chk("R1 busy reads one while running", {47'd0, v[15]}, 48'd1);
    wr(3'd2, 16'hDEAD);
    wr(3'd1, 16'h0FFF);
    wr(3'd0, opWord(1'b0, 3'd3, 6'd9));
    for (int i = 0; i < 100; i++) begin
      rd(3'd0, v);
      if (!v[15]) break;
    end
    chk("R1 busy clears", {47'd0, v[15]}, 48'd0);
    chk("R2 command write ignored while busy", {32'd0, v}, {32'd0, opWord(1'b0, 3'd0, 6'd1)});
    getMac(m);
    chk("R2 mac write ignored while busy", m, 48'hAAAA_BBBB_CCCC);
    rd(3'd1, v);
    chk("R2 data write ignored while busy", {32'd0, v}, {32'd0, 16'h0123});
  endtask

  task automatic t_flush();
    flushAll();
    loadEntry(6'd1, 48'd1, 4'h7, 8'h01, 1'b0);
    loadEntry(6'd1, 48'd2, 4'hF, 8'h01, 1'b0);
    loadEntry(6'd2, 48'd3, 4'h7, 8'h01, 1'b0);
    loadEntry(6'd2, 48'd4, 4'hF, 8'h01, 1'b0);
    wr(3'd1, 16'h0000); runOp(3'd6, 6'd1);
    setMac(48'd0);
    expectNext("R11 db non-static flush keeps static", 6'd1, 48'd2, dataWord(1'b0, 8'h01, 4'hF));
    setMac(48'd0);
    expectNext("R11 db scoped flush spares other db", 6'd2, 48'd3, dataWord(1'b0, 8'h01, 4'h7));
    wr(3'd1, 16'h0000); runOp(3'd2, 6'd0);
    setMac(48'd0);
    expectNext("R11 global non-static flush", 6'd2, 48'd4, dataWord(1'b0, 8'h01, 4'hF));
    wr(3'd1, 16'h0000); runOp(3'd5, 6'd2);
    setMac(48'd0);
    expectNext("R11 db flush of all classes", 6'd2, ALL1, 16'h0000);
    setMac(48'd0);
    expectNext("R11 db flush spares db 1", 6'd1, 48'd2, dataWord(1'b0, 8'h01, 4'hF));
    flushAll();
    setMac(48'd0);
    expectNext("R11 global flush empties table", 6'd1, ALL1, 16'h0000);
  endtask

  task automatic t_move();
    loadEntry(6'd1, 48'd5, 4'h7, 8'h04, 1'b0);
    loadEntry(6'd1, 48'd6, 4'h7, 8'h06, 1'b0);
    loadEntry(6'd2, 48'd7, 4'h7, 8'h04, 1'b0);
    wr(3'd1, dataWord(1'b0, 8'h52, 4'hF)); runOp(3'd5, 6'd1);
    setMac(48'd0);
    expectNext("R12 move port 2 to 5", 6'd1, 48'd5, dataWord(1'b0, 8'h20, 4'h7));
    expectNext("R12 move keeps other ports", 6'd1, 48'd6, dataWord(1'b0, 8'h22, 4'h7));
    setMac(48'd0);
    expectNext("R12 move spares other db", 6'd2, 48'd7, dataWord(1'b0, 8'h04, 4'h7));
    wr(3'd1, dataWord(1'b0, 8'hF1, 4'hF)); runOp(3'd1, 6'd0);
    setMac(48'd5);
    expectNext("R12 remove port 1", 6'd1, 48'd6, dataWord(1'b0, 8'h20, 4'h7));
  endtask

  task automatic t_full();
    logic [15:0] v;
    flushAll();
    for (int i = 0; i < 16; i++) loadEntry(6'd0, 48'h100 + 48'(i), 4'h7, 8'h01, 1'b0);
    rd(3'd0, v);
    chk("R7 no flag while space remains", {47'd0, v[4]}, 48'd0);
    loadEntry(6'd0, 48'h200, 4'h7, 8'h01, 1'b0);
    rd(3'd0, v);
    chk("R7 full flag set", {47'd0, v[4]}, 48'd1);
    loadEntry(6'd0, 48'h105, 4'hE, 8'h02, 1'b0);
    rd(3'd0, v);
    chk("R7 overwrite succeeds when full", {47'd0, v[4]}, 48'd0);
    setMac(48'h1FF);
    expectNext("R7 rejected entry absent", 6'd0, ALL1, 16'h0000);
    setMac(48'h104);
    expectNext("R7 overwritten entry", 6'd0, 48'h105, dataWord(1'b0, 8'h02, 4'hE));
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_layout();
    t_walk();
    t_loadPurge();
    t_busyIgnore();
    t_flush();
    t_move();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule